// File: doc/BRIEF.md
# Single-byte three-wire serial master

This block is a clocked-serial master that moves one byte in each direction at once over three wires: a serial clock it drives, a data line it drives and a data line it samples. Software reaches it through a small register port with four addresses: a control register, the data/shift register, a status register and a clock divider. Setting the enable bit with the auto-transfer bit clear puts the unit in single-byte mode. A write to the data register then launches one eight-bit exchange.

The serial clock idles high. Its half-period is the divider value plus one system clock. Outgoing bits leave most-significant first, each driven at a serial-clock falling edge. The incoming level is captured at that same falling edge and shifted into the shared register at the next rising edge. After eight periods the register holds the received byte. The busy flag drops and a one-cycle interrupt pulse fires together with it. To only receive, software writes any dummy byte. The register port has no back-pressure: every write is taken in the cycle it is presented. A data write during a transfer is discarded and recorded in a sticky overrun flag instead. Software should change the divider only while the unit is idle.

Top module: `sbyte_serial_master`

## Requirements
- R1: After reset the serial clock output is 1, the data output is 1, the control and status registers read 0, the divider reads its reset parameter (1), and the interrupt is 0.
- R2: A write to the data register (address 1) starts a transfer only when control bit 7 (enable) is 1 and control bit 6 (auto-transfer) is 0. Otherwise the byte is only stored and reads back from address 1, with no serial-clock activity.
- R3: In the cycle after a starting write the data output is 0 and the serial clock is still 1.
- R4: With divider value D at address 3 and H = D+1, the serial clock makes its first falling edge H cycles after the starting write, then toggles every H cycles for exactly eight low/high periods. It is 1 whenever no transfer is active.
- R5: At the k-th falling edge (k = 1..8) the data output takes bit 8-k of the written byte (MSB first) and holds it until the next falling edge.
- R6: The input level sampled at each falling edge is shifted in at the following rising edge. After the transfer, address 1 reads the eight sampled bits with the first one in bit 7. A dummy write of any value performs a receive-only exchange.
- R7: Status bit 0 (busy) is 1 for exactly 16·H cycles, starting in the cycle after the starting write.
- R8: The interrupt output is a single-cycle pulse in the first cycle where busy reads 0 after a completed transfer.
- R9: Control bit 5 has no effect on transfers in single-byte mode.
- R10: A data write while busy does not change the transfer or its result and sets status bit 1 (overrun). Writing address 2 with bit 1 set clears it.
- R11: Clearing the enable bit (or setting bit 6) during a transfer aborts it: busy drops, the serial clock returns high and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-complete pulse |

## Verification
Transfers run with divider values 0, 1 and 2, so the bench can tell a correct half-period from one that is off by a cycle. Byte pairs such as 3C/A5, 81/7E and FF/00 are used so that bit-order or sample-alignment errors change the received byte. A receive-only dummy write and a run with control bit 5 set check that the payload is ignored and the spare mode bit is inert. Writes with enable cleared or auto-transfer set, a write during a transfer, and an abort by disabling mid-transfer check the admission rule, the overrun flag and the quiet abort.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
  localparam int CTL_EN   = 7;
  localparam int CTL_AUTO = 6;
  localparam int ST_BUSY  = 0;
  localparam int ST_OVR   = 1;
endpackage

// File: rtl/ssm_regs.sv
module ssm_regs #(
  parameter int DW      = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic [DW-1:0]    shift_q,
  output logic [DW-1:0]    rdata,
  output logic             active,
  output logic             load,
  output logic             start,
  output logic [DIV_W-1:0] div,
  output logic             ovr
);
  import ssm_pkg::*;

  logic [DW-1:0]    ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;
  logic             data_wr;

  assign data_wr = we && (addr == A_DATA);
  assign active  = ctrl_q[CTL_EN] && !ctrl_q[CTL_AUTO];
  assign load    = data_wr && !busy;
  assign start   = load && active;
  assign div     = div_q;
  assign ovr     = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      ovr_q  <= 1'b0;
    end else begin
      if (we && addr == A_CTRL) ctrl_q <= wdata;
      if (we && addr == A_DIV)  div_q  <= wdata[DIV_W-1:0];
      if (data_wr && busy)
        ovr_q <= 1'b1;
      else if (we && addr == A_STAT && wdata[ST_OVR])
        ovr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_DATA:  rdata = shift_q;
      A_STAT:  rdata = {{(DW-2){1'b0}}, ovr_q, busy};
      default: rdata = DW'(div_q);
    endcase
  end
endmodule

// File: rtl/ssm_tick.sv
module ssm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart)
      cnt_q <= div;
    else if (run) begin
      if (cnt_q == '0) cnt_q <= div;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          load,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          sdi,
  output logic          busy,
  output logic          sclk,
  output logic          sdo,
  output logic          irq,
  output logic [DW-1:0] shift_q
);
  localparam int CNT_W = $clog2(DW);

  logic [CNT_W-1:0] bit_q;
  logic             samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      bit_q   <= '0;
      samp_q  <= 1'b0;
      busy    <= 1'b0;
      sclk    <= 1'b1;
      sdo     <= 1'b1;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load) shift_q <= wdata;
      if (start) begin
        busy  <= 1'b1;
        sdo   <= 1'b0;
        sclk  <= 1'b1;
        bit_q <= '0;
      end else if (busy && !active) begin
        busy <= 1'b0;
        sclk <= 1'b1;
      end else if (busy && tick) begin
        if (sclk) begin
          sclk   <= 1'b0;
          sdo    <= shift_q[DW-1];
          samp_q <= sdi;
        end else begin
          sclk    <= 1'b1;
          shift_q <= {shift_q[DW-2:0], samp_q};
          if (bit_q == CNT_W'(DW-1)) begin
            busy <= 1'b0;
            irq  <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbyte_serial_master.sv
module sbyte_serial_master #(
  parameter int DW      = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sclk_o,
  output logic          sdo_o,
  input  logic          sdi_i,
  output logic          irq_o
);
  logic             busy, active, load, start, ovr, tick;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    shift_q;

  ssm_regs #(.DW(DW), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .shift_q(shift_q), .rdata(reg_rdata), .active(active),
    .load(load), .start(start), .div(div), .ovr(ovr)
  );

  ssm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start), .div(div), .tick(tick)
  );

  ssm_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .load(load), .start(start),
    .wdata(reg_wdata), .tick(tick), .sdi(sdi_i), .busy(busy), .sclk(sclk_o),
    .sdo(sdo_o), .irq(irq_o), .shift_q(shift_q)
  );
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic [1:0] addr,
  input logic       busy,
  input logic       start,
  input logic       sclk,
  input logic       sdo,
  input logic       irq,
  input logic       ovr
);
  assert_idle_clock_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  assert_start_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !sdo && sclk));

  assert_sdo_held_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(sdo));

  assert_irq_at_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  assert_irq_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_overrun_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1 && busy) |=> ovr);
endmodule

bind sbyte_serial_master ssm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .busy(busy),
  .start(start), .sclk(sclk_o), .sdo(sdo_o), .irq(irq_o), .ovr(ovr)
);

// File: tb/sbyte_serial_master_bench.sv
`timescale 1ns/1ps
module sbyte_serial_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sclk_o, sdo_o, irq_o;
  logic       sdi_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbyte_serial_master u_sbyte_serial_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .sdi_i(sdi_i), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on every clock edge
  logic       m_busy, m_sclk, m_sdo, m_irq, m_ovr, m_samp;
  logic [7:0] m_ctrl, m_div, m_tx, m_rx, m_data;
  int         m_t, m_h, m_falls;
  logic [7:0] slave = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 1; m_sdo = 1; m_irq = 0; m_ovr = 0; m_samp = 0;
      m_ctrl = 0; m_div = 8'd1; m_tx = 0; m_rx = 0; m_data = 0;
      m_t = 0; m_h = 2; m_falls = 8;
    end else begin
      automatic bit act = m_ctrl[7] && !m_ctrl[6];
      automatic bit was_busy = m_busy;
      m_irq = 0;
      if (m_busy && !act) begin
        m_busy = 0; m_sclk = 1;
      end else if (m_busy) begin
        m_t++;
        if (m_t % m_h == 0) begin
          automatic int k = m_t / m_h;
          if (k % 2 == 1) begin
            m_sclk = 0; m_sdo = m_tx[7 - (k - 1) / 2]; m_samp = sdi_i; m_falls++;
          end else begin
            m_sclk = 1; m_rx = {m_rx[6:0], m_samp};
            if (k == 16) begin m_busy = 0; m_irq = 1; m_data = m_rx; end
          end
        end
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_ctrl = reg_wdata;
          2'd3: m_div = reg_wdata;
          2'd2: if (reg_wdata[1]) m_ovr = 0;
          default: begin
            if (was_busy) m_ovr = 1;
            else begin
              m_data = reg_wdata;
              if (act) begin
                m_busy = 1; m_t = 0; m_tx = reg_wdata; m_sdo = 0; m_sclk = 1;
                m_falls = 0; m_h = m_div + 1;
              end
            end
          end
        endcase
      end
    end
  end

  // serial slave: presents its next bit after each falling edge
  always @(posedge clk) begin
    #1;
    sdi_i = (m_falls < 8) ? slave[7 - m_falls] : 1'b0;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sclk_o === m_sclk, "R4 sclk", 32'(sclk_o), 32'(m_sclk));
      check(sdo_o === m_sdo, "R5 sdo", 32'(sdo_o), 32'(m_sdo));
      check(irq_o === m_irq, "R8 irq", 32'(irq_o), 32'(m_irq));
      if (!reg_we && reg_addr == 2'd2)
        check(reg_rdata[1:0] === {m_ovr, m_busy}, "R7 status", 32'(reg_rdata[1:0]),
              32'({m_ovr, m_busy}));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd2;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int h,
                      input string tag);
    int busy_n = 0;
    int falls = 0;
    logic prev;
    logic [7:0] d;
    slave = slv;
    wr(2'd1, tx);
    check(sdo_o === 1'b0 && sclk_o === 1'b1, "R3 low before first edge",
          32'({sdo_o, sclk_o}), 32'h1);
    prev = sclk_o;
    do begin
      @(negedge clk);
      if (reg_rdata[0]) busy_n++;
      if (prev && !sclk_o) falls++;
      prev = sclk_o;
    end while (reg_rdata[0] && busy_n < 2000);
    check(busy_n == 16 * h, "R7 busy length", busy_n, 16 * h);
    check(falls == 8, "R4 eight clock periods", falls, 8);
    rd(2'd1, d);
    check(d === slv, tag, d, slv);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(2'd0, d); check(d === 8'h00, "R1 ctrl reset", d, 8'h00);
    rd(2'd3, d); check(d === 8'h01, "R1 divider reset", d, 8'h01);
    rd(2'd2, d); check(d === 8'h00, "R1 status reset", d, 8'h00);
    check(sclk_o === 1 && sdo_o === 1 && irq_o === 0, "R1 pins reset",
          32'({sclk_o, sdo_o, irq_o}), 32'h6);

    // R2 disabled: store only
    wr(2'd1, 8'hA5);
    repeat (10) @(posedge clk);
    rd(2'd1, d); check(d === 8'hA5, "R2 stored when disabled", d, 8'hA5);
    rd(2'd2, d); check(d[0] === 1'b0, "R2 no transfer when disabled", d[0], 0);
    wr(2'd0, 8'hC0);
    wr(2'd1, 8'h5A);
    repeat (10) @(posedge clk);
    rd(2'd2, d); check(d[0] === 1'b0, "R2 no transfer in auto mode", d[0], 0);
    rd(2'd1, d); check(d === 8'h5A, "R2 stored in auto mode", d, 8'h5A);

    // main transfers
    wr(2'd0, 8'h80);
    wr(2'd3, 8'd0);
    xfer(8'h3C, 8'hA5, 1, "R6 rx 3C/A5 div0");
    wr(2'd3, 8'd2);
    xfer(8'h81, 8'h7E, 3, "R6 rx 81/7E div2");
    wr(2'd0, 8'hA0);
    wr(2'd3, 8'd1);
    xfer(8'hFF, 8'h00, 2, "R9 bit5 set FF/00");
    wr(2'd0, 8'h80);
    xfer(8'h00, 8'hC3, 2, "R6 receive-only dummy write");

    // R10 overrun
    slave = 8'h96;
    wr(2'd1, 8'h5A);
    repeat (4) @(posedge clk);
    wr(2'd1, 8'hFF);
    rd(2'd2, d); check(d[1:0] === 2'b11, "R10 overrun set while busy", d[1:0], 2'b11);
    do @(negedge clk); while (reg_rdata[0]);
    rd(2'd1, d); check(d === 8'h96, "R10 ignored write leaves result", d, 8'h96);
    wr(2'd2, 8'h02);
    rd(2'd2, d); check(d === 8'h00, "R10 overrun cleared", d, 8'h00);

    // R11 abort
    slave = 8'h33;
    wr(2'd1, 8'hF0);
    repeat (7) @(posedge clk);
    wr(2'd0, 8'h00);
    rd(2'd2, d); check(d[0] === 1'b0, "R11 abort clears busy", d[0], 0);
    check(sclk_o === 1'b1, "R11 abort clock high", sclk_o, 1);
    repeat (40) @(posedge clk);
    wr(2'd0, 8'h80);
    xfer(8'h6B, 8'h4D, 2, "R6 after abort");

    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule